// File: doc/BRIEF.md
# Interrupt to Core Pin Router

This block takes a set of shared interrupt sources and delivers each active one, meaning both pending and enabled, to one or more processors. Each source has a 32-bit map word that names its destination kind (a numbered core interrupt pin, the non-maskable line, or the yield-qualifier line) and carries a 6-bit pin index. A second per-source field, the destination bitmap, names the processors that receive the source.

Each processor has six core interrupt pins, numbered 0 to 5, which drive processor interrupt inputs 2 to 7. It also has one NMI line and one yield-qualifier line. A processor whose control bit selects external-controller mode does not receive raw pin levels. It receives a vector number instead: the highest pin index among its active pin-routed sources, plus one. All outputs are registered, so each output follows the inputs seen at the previous rising clock edge.

Top module: `irq_pin_router`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is cleared to zero at that edge.
- R2: Map word bit 30 routes a source to NMI, bit 29 to yield-qualifier and bit 31 to a core pin. When several of these bits are set, NMI wins, then yield-qualifier, then pin. A word with none of the three set routes nowhere.
- R3: A source takes part in routing only when its `irq_pend` and `irq_en` bits are both 1.
- R4: Source i reaches processor v only when `dest_sel[i*NUM_PROC+v]` is 1.
- R5: In normal mode (`eic_mode[v]`=0), `core_pins[v*6+p]` is the OR over active sources routed to processor v with destination pin and index p. An index of 6 or more drives no pin.
- R6: In external-controller mode (`eic_mode[v]`=1), processor v's six pins are 0. `eic_vec[v*7 +: 7]` is the largest (index+1) over its active pin-routed sources, which can be up to 64, or 0 when there is none.
- R7: In normal mode `eic_vec` for that processor is 0.
- R8: `nmi_out[v]` and `yq_out[v]` are the OR of the active sources routed to processor v with that destination kind, in either mode.
- R9: Every output changes at the rising edge after the input change that causes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | NUM_INT | Pending flag per source |
| irq_en | input | NUM_INT | Enable flag per source |
| map_words | input | NUM_INT*32 | Map word of source i at bits i*32 +: 32 |
| dest_sel | input | NUM_INT*NUM_PROC | Processor bitmap of source i at bits i*NUM_PROC +: NUM_PROC |
| eic_mode | input | NUM_PROC | External-controller mode per processor |
| core_pins | output | NUM_PROC*6 | Six core pins per processor |
| nmi_out | output | NUM_PROC | NMI line per processor |
| yq_out | output | NUM_PROC | Yield-qualifier line per processor |
| eic_vec | output | NUM_PROC*7 | Vector number per processor, 0 when none |

## Verification
Pin-level OR and vector selection can both happen in the same cycle. They collide when several sources share a processor and that processor's mode bit flips between two clocks. The same collision arises when one source is pin-routed while another with a higher index is routed to NMI. The bench makes both happen, with random mode toggles and directed mixes of map words. A behavioural model recomputes every output from the inputs held at each edge and compares it just after that edge. Together these catch a wrong priority, a pin that stays up in vector mode, and an NMI-routed source leaking into the vector maximum.

// File: rtl/irq_route_pkg.sv
// Package: shared constants and the decoded route record for the pin router.
// Assumes a 32-bit map word with destination flags in the top three bits.
package irq_route_pkg;
    localparam int MAP_W        = 32;
    localparam int PIN_FLAG_BIT = 31;
    localparam int NMI_FLAG_BIT = 30;
    localparam int YQ_FLAG_BIT  = 29;
    localparam int IDX_W        = 6;
    localparam int NUM_PINS     = 6;
    localparam int VEC_W        = IDX_W + 1;
    localparam int PIN_SEL_W    = $clog2(NUM_PINS);

    typedef struct packed {
        logic             to_pin;
        logic             to_nmi;
        logic             to_yq;
        logic [IDX_W-1:0] idx;
    } route_t;
endpackage

// File: rtl/irq_map_decode.sv
// Module: irq_map_decode
// Turns each source's map word into one resolved destination kind, gated by
// pending and enable. Priority NMI > yield-qualifier > pin; no flag = no route.
// Assumes map words are held stable by the register file outside this block.
module irq_map_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_INT = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_INT-1:0]       pend,
    input  logic [NUM_INT-1:0]       en,
    input  logic [NUM_INT*MAP_W-1:0] words,
    output route_t [NUM_INT-1:0]     routes
);
    for (genvar i = 0; i < NUM_INT; i++) begin : g_src
        logic             act;
        logic [MAP_W-1:0] w;
        logic             unused_bits;

        assign w   = words[i*MAP_W +: MAP_W];
        assign act = pend[i] & en[i];
        // Bits between the flags and the index carry nothing here.
        assign unused_bits = ^w[YQ_FLAG_BIT-1:IDX_W];

        // Resolve one destination kind for this source (R2, R3).
        assign routes[i] = '{
            to_nmi: act & w[NMI_FLAG_BIT],
            to_yq:  act & w[YQ_FLAG_BIT] & ~w[NMI_FLAG_BIT],
            to_pin: act & w[PIN_FLAG_BIT] & ~w[NMI_FLAG_BIT] & ~w[YQ_FLAG_BIT],
            idx:    w[IDX_W-1:0]
        };

        // R2: a source never leaves with more than one destination kind.
        a_r2_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({routes[i].to_pin, routes[i].to_nmi, routes[i].to_yq}));
    end
endmodule

// File: rtl/irq_proc_lane.sv
// Module: irq_proc_lane
// One processor's output stage. It ORs the selected sources onto six pins, NMI
// and yield-qualifier, picks the highest (index+1) for external-controller
// mode, and registers everything. Assumes routes are already priority-resolved.
module irq_proc_lane
    import irq_route_pkg::*;
#(
    parameter int NUM_INT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  route_t [NUM_INT-1:0]  routes,
    input  logic [NUM_INT-1:0]    sel,
    input  logic                  eic_mode,
    output logic [NUM_PINS-1:0]   pin_q,
    output logic                  nmi_q,
    output logic                  yq_q,
    output logic [VEC_W-1:0]      vec_q
);
    logic [NUM_PINS-1:0] pin_hit;
    logic                nmi_hit;
    logic                yq_hit;
    logic [VEC_W-1:0]    best;
    logic [VEC_W-1:0]    cand;

    // Combine every source selected for this processor (R4, R5, R6, R8).
    always_comb begin
        pin_hit = '0;
        nmi_hit = 1'b0;
        yq_hit  = 1'b0;
        best    = '0;
        cand    = '0;
        for (int i = 0; i < NUM_INT; i++) begin
            if (sel[i]) begin
                nmi_hit = nmi_hit | routes[i].to_nmi;
                yq_hit  = yq_hit  | routes[i].to_yq;
                if (routes[i].to_pin) begin
                    cand = {1'b0, routes[i].idx} + VEC_W'(1);
                    if (cand > best) best = cand;
                    if (routes[i].idx < IDX_W'(NUM_PINS))
                        pin_hit[routes[i].idx[PIN_SEL_W-1:0]] = 1'b1;
                end
            end
        end
    end

    // Register the outputs; the mode picks pins or vector (R1, R6, R7, R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '0;
            nmi_q <= 1'b0;
            yq_q  <= 1'b0;
            vec_q <= '0;
        end else begin
            pin_q <= eic_mode ? '0 : pin_hit;
            nmi_q <= nmi_hit;
            yq_q  <= yq_hit;
            vec_q <= eic_mode ? best : '0;
        end
    end

    // R6: pins stay quiet in the cycle after vector mode was seen.
    a_r6_eic_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eic_mode) |-> (pin_q == '0));
    // R7: no vector is presented in the cycle after normal mode was seen.
    a_r7_vec_zero_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eic_mode) |-> (vec_q == '0));
    // R6: a vector never exceeds the largest index plus one.
    a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q <= VEC_W'(1 << IDX_W));
endmodule

// File: rtl/irq_pin_router.sv
// Module: irq_pin_router (top)
// Decodes the map words once, turns the per-source processor bitmaps into
// per-processor select vectors, and drives one lane per processor.
// Assumes all inputs are synchronous to clk.
module irq_pin_router
    import irq_route_pkg::*;
#(
    parameter int NUM_INT  = 8,
    parameter int NUM_PROC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_INT-1:0]          irq_pend,
    input  logic [NUM_INT-1:0]          irq_en,
    input  logic [NUM_INT*32-1:0]       map_words,
    input  logic [NUM_INT*NUM_PROC-1:0] dest_sel,
    input  logic [NUM_PROC-1:0]         eic_mode,
    output logic [NUM_PROC*6-1:0]       core_pins,
    output logic [NUM_PROC-1:0]         nmi_out,
    output logic [NUM_PROC-1:0]         yq_out,
    output logic [NUM_PROC*7-1:0]       eic_vec
);
    route_t [NUM_INT-1:0]                 routes;
    logic   [NUM_PROC-1:0][NUM_INT-1:0]   sel_t;

    irq_map_decode #(.NUM_INT(NUM_INT)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (irq_pend),
        .en     (irq_en),
        .words  (map_words),
        .routes (routes)
    );

    // Transpose the per-source bitmaps into per-processor selects (R4).
    always_comb begin
        for (int v = 0; v < NUM_PROC; v++)
            for (int i = 0; i < NUM_INT; i++)
                sel_t[v][i] = dest_sel[i*NUM_PROC + v];
    end

    for (genvar v = 0; v < NUM_PROC; v++) begin : g_lane
        irq_proc_lane #(.NUM_INT(NUM_INT)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .routes   (routes),
            .sel      (sel_t[v]),
            .eic_mode (eic_mode[v]),
            .pin_q    (core_pins[v*NUM_PINS +: NUM_PINS]),
            .nmi_q    (nmi_out[v]),
            .yq_q     (yq_out[v]),
            .vec_q    (eic_vec[v*VEC_W +: VEC_W])
        );
    end

    // R3: with no active source on the previous edge, every output is quiet.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_pend & irq_en) == '0) |->
        (core_pins == '0 && nmi_out == '0 && yq_out == '0 && eic_vec == '0));
endmodule

// File: tb/sim_irq_pin_router.sv
module sim_irq_pin_router;
    localparam int NI = 8;
    localparam int NP = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     pend = '0;
    logic [NI-1:0]     en = '0;
    logic [31:0]       mapw [NI];
    logic [NP-1:0]     dest [NI];
    logic [NP-1:0]     eic = '0;
    logic [NI*32-1:0]  map_flat;
    logic [NI*NP-1:0]  dest_flat;
    logic [NP*6-1:0]   core_pins;
    logic [NP-1:0]     nmi_out;
    logic [NP-1:0]     yq_out;
    logic [NP*7-1:0]   eic_vec;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NI; i++) begin
            map_flat[i*32 +: 32] = mapw[i];
            dest_flat[i*NP +: NP] = dest[i];
        end
    end

    irq_pin_router #(.NUM_INT(NI), .NUM_PROC(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en),
        .map_words(map_flat), .dest_sel(dest_flat), .eic_mode(eic),
        .core_pins(core_pins), .nmi_out(nmi_out), .yq_out(yq_out),
        .eic_vec(eic_vec)
    );

    task automatic chk(input string tag, input int v, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s proc %0d %s actual %0d expected %0d", tag, v, what, act, exp);
        end
    endtask

    // Behavioural reference: outputs expected after the next edge.
    task automatic compare(input string tag);
        for (int v = 0; v < NP; v++) begin
            int pins = 0, nmi = 0, yq = 0, vec = 0;
            for (int i = 0; i < NI; i++) begin
                if (pend[i] && en[i] && dest[i][v]) begin
                    if (mapw[i][30]) nmi = 1;
                    else if (mapw[i][29]) yq = 1;
                    else if (mapw[i][31]) begin
                        int x = int'(mapw[i][5:0]);
                        if (eic[v]) begin
                            if (x + 1 > vec) vec = x + 1;
                        end else if (x < 6) pins |= (1 << x);
                    end
                end
            end
            chk({tag, "/R5-pins"}, v, "pins", int'(core_pins[v*6 +: 6]), pins);
            chk({tag, "/R8-nmi"}, v, "nmi", int'(nmi_out[v]), nmi);
            chk({tag, "/R8-yq"}, v, "yq", int'(yq_out[v]), yq);
            chk({tag, "/R6-R7-vec"}, v, "vec", int'(eic_vec[v*7 +: 7]), vec);
        end
    endtask

    // Inputs are already set; clock once and compare just after the edge (R9).
    task automatic step(input string tag);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic clear_all();
        pend = '0; en = '0; eic = '0;
        for (int i = 0; i < NI; i++) begin mapw[i] = '0; dest[i] = '0; end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_all();
        // R1: outputs cleared under reset, even with live inputs
        pend = '1; en = '1;
        for (int i = 0; i < NI; i++) begin mapw[i] = 32'h8000_0001; dest[i] = '1; end
        @(posedge clk); @(posedge clk); #1;
        chk("R1", 0, "pins", int'(core_pins), 0);
        chk("R1", 0, "nmi", int'(nmi_out), 0);
        chk("R1", 0, "vec", int'(eic_vec), 0);
        rst_n = 1'b1;
        step("R9");

        // R2: priority among the flags
        clear_all();
        pend[0] = 1; en[0] = 1; dest[0] = 4'b0001;
        mapw[0] = 32'hE000_0002; step("R2");
        chk("R2", 0, "nmi wins", int'(nmi_out[0]), 1);
        mapw[0] = 32'hA000_0002; step("R2");
        chk("R2", 0, "yq over pin", int'(yq_out[0]), 1);
        mapw[0] = 32'h0FFF_FFC2; step("R2");
        chk("R2", 0, "no flag", int'(core_pins[5:0]), 0);
        mapw[0] = 32'h8000_0002; step("R2");
        chk("R2", 0, "pin2", int'(core_pins[5:0]), 4);

        // R3: enable gates a pending source
        en[0] = 0; step("R3");
        chk("R3", 0, "disabled", int'(core_pins[5:0]), 0);
        en[0] = 1; pend[0] = 0; step("R3");

        // R4: only selected processors
        pend[0] = 1; dest[0] = 4'b0100; step("R4");
        chk("R4", 2, "pin2", int'(core_pins[17:12]), 4);
        chk("R4", 0, "unselected", int'(core_pins[5:0]), 0);

        // R5: index 6 and above reach no pin
        mapw[0] = 32'h8000_0006; step("R5");
        chk("R5", 2, "idx6", int'(core_pins[17:12]), 0);

        // R6: highest vector; NMI source with larger index does not count
        eic[2] = 1;
        pend[1] = 1; en[1] = 1; dest[1] = 4'b0100; mapw[1] = 32'h8000_0028;
        pend[2] = 1; en[2] = 1; dest[2] = 4'b0100; mapw[2] = 32'h4000_003F;
        step("R6");
        chk("R6", 2, "vec", int'(eic_vec[20:14]), 41);
        mapw[1] = 32'h8000_003F; step("R6");
        chk("R6", 2, "vec max", int'(eic_vec[20:14]), 64);
        // R7: back to normal mode
        eic[2] = 0; step("R7");
        chk("R7", 2, "vec", int'(eic_vec[20:14]), 0);

        // Random mix with mode toggles, compared every clock
        for (int n = 0; n < 3000; n++) begin
            pend = NI'($urandom); en = NI'($urandom); eic = NP'($urandom);
            for (int i = 0; i < NI; i++) begin
                logic [31:0] r;
                r = $urandom;
                r[5:0] = (r[7:6] == 2'b00) ? r[13:8] : {3'b000, r[10:8]};
                mapw[i] = r;
                dest[i] = NP'($urandom);
            end
            step("RND");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule